// File: doc/BRIEF.md
# DMA Channel Programming Register Port

This block is the register file and bus decoder of a four-channel DMA controller. A host reaches it over an 8-bit I/O port with a 4-bit register offset, a write strobe, a read strobe and separate data in and out. Each channel stores a 16-bit base address, a current address, a base count, a current count and a mode byte. One command byte, a 4-bit channel mask, an 8-bit status byte and a single byte-pointer flip-flop are shared by the four channels. Because the port is 8 bits wide, each 16-bit word is reached as two byte accesses, and the flip-flop selects which byte an access touches.

Every stored value is presented in parallel to a transfer engine. The engine writes back updated current address and count values, raises terminal-count flags and sets mask bits when a channel finishes. The block does no arbitration and no memory cycles. It only holds state, decodes the bus and merges the engine's updates with the host's.

Top module: `dmac_prog_port`

## Requirements
- R1: A synchronous reset clears every address, count, mode, command, mask and status register and the byte-pointer flip-flop.
- R2: For offsets 0 to 7, offset bits [2:1] give the channel. Offset bit 0 = 0 selects the address word and bit 0 = 1 selects the count word. Reads return the current word. The host never raises both strobes in one cycle, and the read data is zero while the read strobe is low.
- R3: One flip-flop is shared by all channels. It toggles on every read or write at offsets 0 to 7. An access made while it is 0 touches bits [7:0], and an access made while it is 1 touches bits [15:8].
- R4: A low-byte write sets the base word to the data byte zero-extended. A high-byte write ORs the data byte into base bits [15:8]. After either write, the current word equals the new base word.
- R5: A write at offset 8 loads the command byte. A read at offset 8 returns the status byte, and at the clock edge status bits [3:0] are cleared while bits [7:4] are kept.
- R6: A write at offset 9 sets status bit 4+n when data bit 2 is 1 and clears it when data bit 2 is 0, where n is data[1:0].
- R7: A write at offset A sets mask bit n (n = data[1:0]) when data bit 2 is 1 and clears it when data bit 2 is 0. The other mask bits are left unchanged.
- R8: A write at offset B stores the data with bits [1:0] forced to zero as the mode of channel data[1:0], and clears status bit data[1:0].
- R9: A write at offset C clears the flip-flop. A write at offset D sets all four mask bits and clears the command, the status and the flip-flop.
- R10: A write at offset E clears the mask. A write at offset F loads the mask from data[3:0]. A read at offset F returns the mask in bits [3:0] with zeros above. Reads at offsets 9 to E return zero.
- R11: An engine write-back on channel n loads that channel's current address and current count and leaves the base words unchanged. In the same cycle, a host byte write to one of those words takes precedence for that word only.
- R12: Engine terminal-count flags set status bits [3:0], and engine mask requests set mask bits. Both win over a host action in the same cycle that would clear the same bits (status read, mode write, master clear, mask clear).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_off | input | 4 | Register offset |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| eng_base_addr | output | 64 | Base address words, channel n at [16n+15:16n] |
| eng_cur_addr | output | 64 | Current address words |
| eng_base_cnt | output | 64 | Base count words |
| eng_cur_cnt | output | 64 | Current count words |
| eng_mode | output | 32 | Mode bytes, channel n at [8n+7:8n] |
| eng_cmd | output | 8 | Command byte |
| eng_mask | output | 4 | Channel mask |
| eng_status | output | 8 | Status: terminal count in [3:0], request in [7:4] |
| eng_wb_en | input | 4 | Per-channel write-back of current address and count |
| eng_wb_addr | input | 64 | Write-back address values |
| eng_wb_cnt | input | 64 | Write-back count values |
| eng_tc | input | 4 | Per-channel terminal-count flags |
| eng_mask_set | input | 4 | Per-channel mask-set requests |

## Verification
Two functions can fall in the same cycle: a host action and an engine update that target the same register. The bench provokes this in four ways. It reads status while the engine raises a terminal count on another channel. It writes a mode byte while the engine flags the channel whose bit that write clears. It clears the mask while the engine sets a mask bit. It writes the low byte of an address word while the engine writes back that channel's address and count. Each result is judged from the read data and the engine-side outputs on the following cycle: the engine's set bits must survive while the clears act on the other bits, and in the write-back case the host byte must land in the address word while the engine value lands in the count.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   // register offsets whose position is fixed by the decoder
   localparam logic [3:0] OFS_STATUS    = 4'h8;
   localparam logic [3:0] OFS_REQUEST   = 4'h9;
   localparam logic [3:0] OFS_MASK_ONE  = 4'hA;
   localparam logic [3:0] OFS_MODE      = 4'hB;
   localparam logic [3:0] OFS_PTR_CLR   = 4'hC;
   localparam logic [3:0] OFS_RESET_ALL = 4'hD;
   localparam logic [3:0] OFS_MASK_CLR  = 4'hE;
   localparam logic [3:0] OFS_MASK_ALL  = 4'hF;
   // data bit selecting set (1) or clear (0) for request and mask
   localparam int unsigned SET_BIT = 2;
   typedef logic [3:0] reg_ofs_t;
endpackage

// File: rtl/dmac_word_reg.sv
module dmac_word_reg #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bw_en,
   input  logic              bw_hi,
   input  logic [BYTE_W-1:0] bw_data,
   input  logic              ld_en,
   input  logic [WORD_W-1:0] ld_val,
   output logic [WORD_W-1:0] base_q,
   output logic [WORD_W-1:0] cur_q
);
   if (WORD_W != 2 * BYTE_W) begin : g_bad_width
      $error("dmac_word_reg: WORD_W must be twice BYTE_W");
   end

   logic [WORD_W-1:0] ext;
   logic [WORD_W-1:0] base_nxt;

   always_comb begin
      ext      = WORD_W'(bw_data);
      base_nxt = bw_hi ? (base_q | (ext << BYTE_W)) : ext;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (bw_en) begin
         base_q <= base_nxt;
         cur_q  <= base_nxt;
      end else if (ld_en) begin
         cur_q  <= ld_val;
      end
   end

   // R4: low byte zero-extends into base, current follows base
   assert_low_load_R4: assert property (@(posedge clk) disable iff (rst)
      (bw_en && !bw_hi) |=> (base_q == WORD_W'($past(bw_data)) && cur_q == base_q));
   // R4: high byte keeps the low byte already held
   assert_high_keep_R4: assert property (@(posedge clk) disable iff (rst)
      (bw_en && bw_hi) |=> (base_q[BYTE_W-1:0] == $past(base_q[BYTE_W-1:0])));
   // R11: engine load moves current only
   assert_eng_load_R11: assert property (@(posedge clk) disable iff (rst)
      (ld_en && !bw_en) |=> (cur_q == $past(ld_val) && $stable(base_q)));
endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
   import dmac_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned CHANNELS = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr,
   input  logic                  rd,
   input  reg_ofs_t              off,
   input  logic [BYTE_W-1:0]     wdata,
   input  logic [CHANNELS-1:0]   eng_tc,
   input  logic [CHANNELS-1:0]   eng_mask_set,
   output logic [BYTE_W-1:0]     cmd_q,
   output logic [CHANNELS-1:0]   mask_q,
   output logic [2*CHANNELS-1:0] status_q,
   output logic                  ff_q
);
   localparam int unsigned IDX_W = $clog2(CHANNELS);
   localparam int unsigned ST_W  = 2 * CHANNELS;

   logic [CHANNELS-1:0] sel;
   logic                word_acc;
   logic                ff_n;
   logic [BYTE_W-1:0]   cmd_n;
   logic [CHANNELS-1:0] mask_n;
   logic [ST_W-1:0]     status_n;

   always_comb begin
      sel                    = '0;
      sel[wdata[IDX_W-1:0]]  = 1'b1;
      word_acc               = (wr || rd) && !off[3];

      ff_n = ff_q;
      if (wr && (off == OFS_PTR_CLR || off == OFS_RESET_ALL)) ff_n = 1'b0;
      else if (word_acc)                                       ff_n = ~ff_q;

      cmd_n    = cmd_q;
      mask_n   = mask_q;
      status_n = status_q;
      if (rd && off == OFS_STATUS) status_n[CHANNELS-1:0] = '0;
      if (wr) begin
         case (off)
            OFS_STATUS:    cmd_n = wdata;
            OFS_REQUEST:   status_n[ST_W-1:CHANNELS] = wdata[SET_BIT] ?
                              (status_q[ST_W-1:CHANNELS] | sel) : (status_q[ST_W-1:CHANNELS] & ~sel);
            OFS_MASK_ONE:  mask_n = wdata[SET_BIT] ? (mask_q | sel) : (mask_q & ~sel);
            OFS_MODE:      status_n[CHANNELS-1:0] = status_q[CHANNELS-1:0] & ~sel;
            OFS_RESET_ALL: begin
               mask_n   = '1;
               cmd_n    = '0;
               status_n = '0;
            end
            OFS_MASK_CLR:  mask_n = '0;
            OFS_MASK_ALL:  mask_n = wdata[CHANNELS-1:0];
            default:       ;
         endcase
      end
      // engine updates are merged last so they survive host clears
      status_n[CHANNELS-1:0] = status_n[CHANNELS-1:0] | eng_tc;
      mask_n                 = mask_n | eng_mask_set;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q    <= '0;
         mask_q   <= '0;
         status_q <= '0;
         ff_q     <= 1'b0;
      end else begin
         cmd_q    <= cmd_n;
         mask_q   <= mask_n;
         status_q <= status_n;
         ff_q     <= ff_n;
      end
   end

   // R2: host strobes are exclusive
   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst) !(wr && rd));
   // R3: every word access flips the shared pointer
   assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (rst)
      word_acc |=> (ff_q != $past(ff_q)));
   // R5: status read drops terminal counts, keeps requests
   assert_stat_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (rd && off == OFS_STATUS && eng_tc == '0) |=>
         (status_q[CHANNELS-1:0] == '0 && status_q[ST_W-1:CHANNELS] == $past(status_q[ST_W-1:CHANNELS])));
   // R6: request set lands on the selected channel
   assert_req_set_R6: assert property (@(posedge clk) disable iff (rst)
      (wr && off == OFS_REQUEST && wdata[SET_BIT]) |=>
         ((status_q[ST_W-1:CHANNELS] & $past(sel)) == $past(sel)));
   // R9: master clear
   assert_master_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (wr && off == OFS_RESET_ALL && eng_tc == '0) |=>
         (mask_q == '1 && cmd_q == '0 && status_q == '0 && !ff_q));
   // R12: engine flags are never lost
   assert_eng_flags_R12: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (((status_q[CHANNELS-1:0] & $past(eng_tc)) == $past(eng_tc)) &&
                ((mask_q & $past(eng_mask_set)) == $past(eng_mask_set))));
endmodule

// File: rtl/dmac_rd_mux.sv
module dmac_rd_mux
   import dmac_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CHANNELS = 4
) (
   input  logic                         rd,
   input  reg_ofs_t                     off,
   input  logic                         ff,
   input  logic [CHANNELS*WORD_W-1:0]   cur_addr,
   input  logic [CHANNELS*WORD_W-1:0]   cur_cnt,
   input  logic [2*CHANNELS-1:0]        status,
   input  logic [CHANNELS-1:0]          mask,
   output logic [BYTE_W-1:0]            rdata
);
   localparam int unsigned IDX_W = $clog2(CHANNELS);

   logic [IDX_W-1:0]  ch;
   logic [WORD_W-1:0] word;

   always_comb begin
      ch    = off[IDX_W:1];
      word  = off[0] ? cur_cnt[int'(ch)*WORD_W +: WORD_W]
                     : cur_addr[int'(ch)*WORD_W +: WORD_W];
      rdata = '0;
      if (rd) begin
         if (!off[3])                  rdata = ff ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
         else if (off == OFS_STATUS)   rdata = BYTE_W'(status);
         else if (off == OFS_MASK_ALL) rdata = BYTE_W'(mask);
      end
   end
endmodule

// File: rtl/dmac_prog_port.sv
module dmac_prog_port
   import dmac_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CHANNELS = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [3:0]                 io_off,
   input  logic                       io_wr,
   input  logic                       io_rd,
   input  logic [BYTE_W-1:0]          io_wdata,
   output logic [BYTE_W-1:0]          io_rdata,
   output logic [CHANNELS*WORD_W-1:0] eng_base_addr,
   output logic [CHANNELS*WORD_W-1:0] eng_cur_addr,
   output logic [CHANNELS*WORD_W-1:0] eng_base_cnt,
   output logic [CHANNELS*WORD_W-1:0] eng_cur_cnt,
   output logic [CHANNELS*BYTE_W-1:0] eng_mode,
   output logic [BYTE_W-1:0]          eng_cmd,
   output logic [CHANNELS-1:0]        eng_mask,
   output logic [2*CHANNELS-1:0]      eng_status,
   input  logic [CHANNELS-1:0]        eng_wb_en,
   input  logic [CHANNELS*WORD_W-1:0] eng_wb_addr,
   input  logic [CHANNELS*WORD_W-1:0] eng_wb_cnt,
   input  logic [CHANNELS-1:0]        eng_tc,
   input  logic [CHANNELS-1:0]        eng_mask_set
);
   localparam int unsigned IDX_W = $clog2(CHANNELS);

   if (CHANNELS != 4) begin : g_bad_chan
      $error("dmac_prog_port: the offset map serves exactly four channels");
   end
   if (2 * CHANNELS != BYTE_W) begin : g_bad_status
      $error("dmac_prog_port: status must fill one bus byte");
   end

   logic ff_q;

   dmac_ctrl_regs #(.BYTE_W(BYTE_W), .CHANNELS(CHANNELS)) i_ctrl (
      .clk          (clk),
      .rst          (rst),
      .wr           (io_wr),
      .rd           (io_rd),
      .off          (io_off),
      .wdata        (io_wdata),
      .eng_tc       (eng_tc),
      .eng_mask_set (eng_mask_set),
      .cmd_q        (eng_cmd),
      .mask_q       (eng_mask),
      .status_q     (eng_status),
      .ff_q         (ff_q)
   );

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      logic              hit;
      logic              mode_wr;
      logic [BYTE_W-1:0] mode_q;

      assign hit     = io_wr && !io_off[3] && (io_off[IDX_W:1] == IDX_W'(c));
      assign mode_wr = io_wr && (io_off == OFS_MODE) && (io_wdata[IDX_W-1:0] == IDX_W'(c));

      dmac_word_reg #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) i_addr (
         .clk     (clk),
         .rst     (rst),
         .bw_en   (hit && !io_off[0]),
         .bw_hi   (ff_q),
         .bw_data (io_wdata),
         .ld_en   (eng_wb_en[c]),
         .ld_val  (eng_wb_addr[c*WORD_W +: WORD_W]),
         .base_q  (eng_base_addr[c*WORD_W +: WORD_W]),
         .cur_q   (eng_cur_addr[c*WORD_W +: WORD_W])
      );

      dmac_word_reg #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) i_cnt (
         .clk     (clk),
         .rst     (rst),
         .bw_en   (hit && io_off[0]),
         .bw_hi   (ff_q),
         .bw_data (io_wdata),
         .ld_en   (eng_wb_en[c]),
         .ld_val  (eng_wb_cnt[c*WORD_W +: WORD_W]),
         .base_q  (eng_base_cnt[c*WORD_W +: WORD_W]),
         .cur_q   (eng_cur_cnt[c*WORD_W +: WORD_W])
      );

      always_ff @(posedge clk) begin
         if (rst)          mode_q <= '0;
         else if (mode_wr) mode_q <= {io_wdata[BYTE_W-1:IDX_W], {IDX_W{1'b0}}};
      end
      assign eng_mode[c*BYTE_W +: BYTE_W] = mode_q;

      // R8: mode byte takes the written data with the channel field zeroed
      assert_mode_load_R8: assert property (@(posedge clk) disable iff (rst)
         mode_wr |=> (mode_q[BYTE_W-1:IDX_W] == $past(io_wdata[BYTE_W-1:IDX_W]) &&
                      mode_q[IDX_W-1:0] == '0));
   end

   dmac_rd_mux #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .CHANNELS(CHANNELS)) i_rmux (
      .rd       (io_rd),
      .off      (io_off),
      .ff       (ff_q),
      .cur_addr (eng_cur_addr),
      .cur_cnt  (eng_cur_cnt),
      .status   (eng_status),
      .mask     (eng_mask),
      .rdata    (io_rdata)
   );

   // R2: idle read port drives zero
   assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (rst)
      !io_rd |-> (io_rdata == '0));
endmodule

// File: tb/test_dmac_prog_port.sv
module test_dmac_prog_port;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  io_off = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [63:0] eng_base_addr, eng_cur_addr, eng_base_cnt, eng_cur_cnt;
   logic [31:0] eng_mode;
   logic [7:0]  eng_cmd;
   logic [3:0]  eng_mask;
   logic [7:0]  eng_status;
   logic [3:0]  eng_wb_en = '0;
   logic [63:0] eng_wb_addr = '0;
   logic [63:0] eng_wb_cnt = '0;
   logic [3:0]  eng_tc = '0;
   logic [3:0]  eng_mask_set = '0;

   // engine stimulus staged for the next bus operation
   logic [3:0]  p_wb_en = '0;
   logic [63:0] p_wb_addr = '0;
   logic [63:0] p_wb_cnt = '0;
   logic [3:0]  p_tc = '0;
   logic [3:0]  p_mask = '0;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   dmac_prog_port i_dmac_prog_port (
      .clk, .rst, .io_off, .io_wr, .io_rd, .io_wdata, .io_rdata,
      .eng_base_addr, .eng_cur_addr, .eng_base_cnt, .eng_cur_cnt,
      .eng_mode, .eng_cmd, .eng_mask, .eng_status,
      .eng_wb_en, .eng_wb_addr, .eng_wb_cnt, .eng_tc, .eng_mask_set
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares read data mid-cycle
   always @(negedge clk) begin
      if (!rst && io_rd) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2 actual %h expected none (unscheduled read)", io_rdata);
         end else begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (io_rdata !== e) begin
               errors++;
               $display("FAIL %s actual %h expected %h", t, io_rdata, e);
            end
         end
      end
   end

   task automatic bus_op(input logic w, input logic r, input logic [3:0] o, input logic [7:0] d);
      @(posedge clk);
      #2;
      io_wr = w; io_rd = r; io_off = o; io_wdata = d;
      eng_wb_en = p_wb_en; eng_wb_addr = p_wb_addr; eng_wb_cnt = p_wb_cnt;
      eng_tc = p_tc; eng_mask_set = p_mask;
      @(posedge clk);
      #2;
      io_wr = 1'b0; io_rd = 1'b0; io_off = '0; io_wdata = '0;
      eng_wb_en = '0; eng_tc = '0; eng_mask_set = '0;
      p_wb_en = '0; p_tc = '0; p_mask = '0;
   endtask

   task automatic wr(input logic [3:0] o, input logic [7:0] d);
      bus_op(1'b1, 1'b0, o, d);
   endtask

   task automatic rd(input logic [3:0] o, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_op(1'b0, 1'b1, o, 8'h00);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst = 1'b0;
      @(negedge clk);
      // R1: everything cleared
      chk("R1 cmd", {24'h0, eng_cmd}, 32'h0);
      chk("R1 mask", {28'h0, eng_mask}, 32'h0);
      chk("R1 status", {24'h0, eng_status}, 32'h0);
      chk("R1 cur_addr", eng_cur_addr[31:0] | eng_cur_addr[63:32], 32'h0);
      chk("R1 mode", eng_mode, 32'h0);
      rd(4'h0, 8'h00, "R1 read ch0 addr");
      wr(4'hC, 8'h00);

      // R4 / R2: channel 1 address, low then high
      wr(4'h2, 8'h34);
      wr(4'h2, 8'h12);
      chk("R4 ch1 base addr", {16'h0, eng_base_addr[31:16]}, 32'h1234);
      chk("R4 ch1 cur addr", {16'h0, eng_cur_addr[31:16]}, 32'h1234);
      rd(4'h2, 8'h34, "R3 ch1 addr low");
      rd(4'h2, 8'h12, "R3 ch1 addr high");

      // R3: pointer shared across channels and across reads and writes
      wr(4'h3, 8'hCD);
      rd(4'h0, 8'h00, "R3 ch0 addr high after foreign write");
      wr(4'h3, 8'hAB);
      chk("R3 ch1 base cnt", {16'h0, eng_base_cnt[31:16]}, 32'h00AB);
      wr(4'h3, 8'h56);
      rd(4'h3, 8'hAB, "R2 ch1 count low");
      rd(4'h3, 8'h56, "R2 ch1 count high");

      // R4: high byte ORs into what is already there
      wr(4'h6, 8'h11);
      wr(4'h6, 8'h0F);
      rd(4'h6, 8'h11, "R4 ch3 addr low");
      wr(4'h6, 8'hF0);
      chk("R4 ch3 base OR", {16'h0, eng_base_addr[63:48]}, 32'hFF11);
      chk("R4 ch3 cur OR", {16'h0, eng_cur_addr[63:48]}, 32'hFF11);

      // R5: command load
      wr(4'h8, 8'h5A);
      chk("R5 command", {24'h0, eng_cmd}, 32'h5A);

      // R6: request bits
      wr(4'h9, 8'h06);
      wr(4'h9, 8'h04);
      chk("R6 request set", {24'h0, eng_status}, 32'h50);
      wr(4'h9, 8'h02);
      chk("R6 request clear", {24'h0, eng_status}, 32'h10);
      wr(4'h9, 8'h06);

      // R12 / R5: engine terminal counts then status read
      p_tc = 4'b0011;
      bus_op(1'b0, 1'b0, 4'h0, 8'h00);
      chk("R12 tc set", {24'h0, eng_status}, 32'h53);
      rd(4'h8, 8'h53, "R5 status read");
      chk("R5 status after read", {24'h0, eng_status}, 32'h50);

      // R8: mode write clears that channel's terminal count
      p_tc = 4'b0010;
      bus_op(1'b0, 1'b0, 4'h0, 8'h00);
      wr(4'hB, 8'hD5);
      chk("R8 mode ch1", {24'h0, eng_mode[15:8]}, 32'hD4);
      chk("R8 mode ch0 untouched", {24'h0, eng_mode[7:0]}, 32'h00);
      chk("R8 tc cleared", {24'h0, eng_status}, 32'h50);

      // R7: single mask bits
      wr(4'hA, 8'h05);
      wr(4'hA, 8'h07);
      chk("R7 mask two set", {28'h0, eng_mask}, 32'hA);
      wr(4'hA, 8'h03);
      chk("R7 mask one cleared", {28'h0, eng_mask}, 32'h2);
      rd(4'hF, 8'h02, "R10 mask read");

      // R10: whole-mask load and clear, zero reads
      wr(4'hF, 8'h9C);
      chk("R10 mask load", {28'h0, eng_mask}, 32'hC);
      wr(4'hE, 8'h00);
      chk("R10 mask clear", {28'h0, eng_mask}, 32'h0);
      rd(4'hD, 8'h00, "R10 read D");
      rd(4'h9, 8'h00, "R10 read 9");
      rd(4'hA, 8'h00, "R10 read A");
      rd(4'hB, 8'h00, "R10 read B");
      rd(4'hC, 8'h00, "R10 read C");
      rd(4'hE, 8'h00, "R10 read E");

      // R9: master clear and pointer clear
      wr(4'h0, 8'h77);
      wr(4'hD, 8'h00);
      chk("R9 mask set", {28'h0, eng_mask}, 32'hF);
      chk("R9 cmd cleared", {24'h0, eng_cmd}, 32'h0);
      chk("R9 status cleared", {24'h0, eng_status}, 32'h0);
      rd(4'h0, 8'h77, "R9 pointer cleared by master clear");
      wr(4'hC, 8'h00);
      wr(4'h0, 8'h22);
      wr(4'hC, 8'h00);
      wr(4'h0, 8'h33);
      chk("R9 pointer clear", {16'h0, eng_base_addr[15:0]}, 32'h0033);
      wr(4'hC, 8'h00);

      // R11: engine write-back
      p_wb_en = 4'b0100;
      p_wb_addr[47:32] = 16'hBEEF;
      p_wb_cnt[47:32]  = 16'h0102;
      bus_op(1'b0, 1'b0, 4'h0, 8'h00);
      chk("R11 wb cur addr", {16'h0, eng_cur_addr[47:32]}, 32'hBEEF);
      chk("R11 wb base kept", {16'h0, eng_base_addr[47:32]}, 32'h0000);
      rd(4'h4, 8'hEF, "R11 wb addr low");
      rd(4'h4, 8'hBE, "R11 wb addr high");
      rd(4'h5, 8'h02, "R11 wb cnt low");
      rd(4'h5, 8'h01, "R11 wb cnt high");

      // R11: host byte write and write-back in the same cycle
      p_wb_en = 4'b0100;
      p_wb_addr[47:32] = 16'h1111;
      p_wb_cnt[47:32]  = 16'h2222;
      wr(4'h4, 8'h99);
      chk("R11 host wins addr", {16'h0, eng_cur_addr[47:32]}, 32'h0099);
      chk("R11 engine wins cnt", {16'h0, eng_cur_cnt[47:32]}, 32'h2222);
      wr(4'hC, 8'h00);

      // R12: engine flags against same-cycle host clears
      wr(4'h9, 8'h05);
      p_tc = 4'b0001;
      bus_op(1'b0, 1'b0, 4'h0, 8'h00);
      p_tc = 4'b1000;
      rd(4'h8, 8'h21, "R12 status read with tc");
      chk("R12 tc survives read clear", {24'h0, eng_status}, 32'h28);
      p_mask = 4'b0100;
      wr(4'hE, 8'h00);
      chk("R12 mask set beats clear", {28'h0, eng_mask}, 32'h4);
      p_tc = 4'b1000;
      wr(4'hB, 8'h03);
      chk("R12 tc beats mode clear", {24'h0, eng_status}, 32'h28);
      chk("R8 mode ch3", {24'h0, eng_mode[31:24]}, 32'h00);

      repeat (2) @(posedge clk);
      chk("R2 scoreboard drained", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule